// File: doc/BRIEF.md
# Configurable Stream Register Slice

This block is one pipeline stage that sits between a producer and a consumer on a valid/ready stream. A beat moves across an interface only in a cycle where valid and ready are both high. The producer may not withdraw valid, or change its data, until that beat has been taken. The consumer may raise or drop ready in any cycle.

The parameter `MODE` picks one of four ways to break up the timing paths:

- **Forward (0)** registers the valid and data paths.
- **Backward (1)** registers the ready path behind a one-entry skid register.
- **Half-rate (2)** uses a single register that holds at most one beat, so it accepts and presents on alternate cycles.
- **Full (3)** chains the backward stage into the forward stage. With this mode, no combinational path crosses the slice in either direction.

Designers choose the mode from the path they need to cut, trading latency against throughput and flops.

Top module: `stream_reg_slice`

## Requirements
- R1: `MODE` must be 0 (forward), 1 (backward), 2 (half-rate) or 3 (full), and `DATA_W` must be at least 1; any other value stops elaboration.
- R2: While `rst` is high and in the first cycle after it falls, `dn_valid` is 0 and `up_ready` is 1 in every mode.
- R3: In every mode, if `dn_valid` is 1 and `dn_ready` is 0 at a clock edge, then after that edge `dn_valid` is still 1 and `dn_data` is unchanged.
- R4: In forward mode, `up_ready` is 1 whenever `dn_valid` is 0 or `dn_ready` is 1. A beat accepted at an edge appears on `dn_valid`/`dn_data` right after that edge (one cycle of latency).
- R5: In backward mode, a beat offered while the skid register is empty appears on the downstream side in the same cycle. If the downstream stalls when that beat is accepted, the beat is kept and `up_ready` is 0 in the next cycle.
- R6: In half-rate mode, `up_ready` and `dn_valid` are never 1 together. A continuous stream with `dn_ready` held high moves one beat every two cycles.
- R7: In backward and full modes, `up_ready` depends only on registers. Changing `dn_ready` within a cycle leaves `up_ready` unchanged.
- R8: In every mode and under any pattern of upstream gaps and downstream stalls, every accepted beat leaves exactly once, in acceptance order, with its data intact.
- R9: With `dn_ready` held high and the upstream always offering, N beats complete in N+1 cycles in forward and full modes and in N cycles in backward mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| up_valid | input | 1 | Upstream beat offered |
| up_ready | output | 1 | Slice can take the upstream beat |
| up_data | input | DATA_W | Upstream beat data |
| dn_valid | output | 1 | Beat offered downstream |
| dn_ready | input | 1 | Downstream takes the beat |
| dn_data | output | DATA_W | Downstream beat data |

## Verification
The hardest state to reach from the ports is the full mode with its skid register occupied, while the forward register also holds a beat and the upstream keeps offering. The bench reaches it by running sparse downstream-ready patterns against a continuous source, so that both stalled-beat paths fill and drain in changing orders. In each of those cycles it also toggles `dn_ready` mid-cycle and checks that `up_ready` does not follow.

// File: rtl/slice_pkg.sv
package slice_pkg;
   localparam int MODE_FWD  = 0;
   localparam int MODE_BWD  = 1;
   localparam int MODE_HALF = 2;
   localparam int MODE_FULL = 3;
   localparam int MODE_LAST = MODE_FULL;
endpackage

// File: rtl/slice_fwd.sv
module slice_fwd #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);
   logic         occ_q;
   logic [W-1:0] data_q;

   // register may load whenever it is empty or being drained
   assign in_ready  = !occ_q || out_ready;
   assign out_valid = occ_q;
   assign out_data  = data_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)
         occ_q <= 1'b0;
      else if (in_ready)
         occ_q <= in_valid;
   end

   always_ff @(posedge clk) begin
      if (in_ready && in_valid)
         data_q <= in_data;
   end
endmodule

// File: rtl/slice_bwd.sv
module slice_bwd #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);
   logic         skid_q;
   logic [W-1:0] skid_data_q;

   // ready comes straight from a flop: no path from out_ready
   assign in_ready  = !skid_q;
   assign out_valid = skid_q || in_valid;
   assign out_data  = skid_q ? skid_data_q : in_data;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)
         skid_q <= 1'b0;
      else if (out_ready)
         skid_q <= 1'b0;
      else if (in_valid && !skid_q)
         skid_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!skid_q && in_valid && !out_ready)
         skid_data_q <= in_data;
   end
endmodule

// File: rtl/slice_half.sv
module slice_half #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);
   logic         full_q;
   logic [W-1:0] data_q;

   assign in_ready  = !full_q;
   assign out_valid = full_q;
   assign out_data  = data_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)
         full_q <= 1'b0;
      else if (!full_q && in_valid)
         full_q <= 1'b1;
      else if (full_q && out_ready)
         full_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!full_q && in_valid)
         data_q <= in_data;
   end
endmodule

// File: rtl/stream_reg_slice.sv
module stream_reg_slice
   import slice_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int MODE   = MODE_FWD
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              up_valid,
   output logic              up_ready,
   input  logic [DATA_W-1:0] up_data,
   output logic              dn_valid,
   input  logic              dn_ready,
   output logic [DATA_W-1:0] dn_data
);
   // R1: reject illegal configurations at elaboration
   if (MODE < 0 || MODE > MODE_LAST) begin : g_bad_mode
      $error("stream_reg_slice: MODE %0d out of range", MODE);
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("stream_reg_slice: DATA_W must be positive");
   end

   if (MODE == MODE_FWD) begin : g_fwd
      slice_fwd #(.W(DATA_W)) u_stage (
         .clk(clk), .rst(rst),
         .in_valid(up_valid), .in_ready(up_ready), .in_data(up_data),
         .out_valid(dn_valid), .out_ready(dn_ready), .out_data(dn_data));
   end else if (MODE == MODE_BWD) begin : g_bwd
      slice_bwd #(.W(DATA_W)) u_stage (
         .clk(clk), .rst(rst),
         .in_valid(up_valid), .in_ready(up_ready), .in_data(up_data),
         .out_valid(dn_valid), .out_ready(dn_ready), .out_data(dn_data));
   end else if (MODE == MODE_HALF) begin : g_half
      slice_half #(.W(DATA_W)) u_stage (
         .clk(clk), .rst(rst),
         .in_valid(up_valid), .in_ready(up_ready), .in_data(up_data),
         .out_valid(dn_valid), .out_ready(dn_ready), .out_data(dn_data));
   end else begin : g_full
      logic              mid_valid;
      logic              mid_ready;
      logic [DATA_W-1:0] mid_data;

      slice_bwd #(.W(DATA_W)) u_back (
         .clk(clk), .rst(rst),
         .in_valid(up_valid), .in_ready(up_ready), .in_data(up_data),
         .out_valid(mid_valid), .out_ready(mid_ready), .out_data(mid_data));

      slice_fwd #(.W(DATA_W)) u_front (
         .clk(clk), .rst(rst),
         .in_valid(mid_valid), .in_ready(mid_ready), .in_data(mid_data),
         .out_valid(dn_valid), .out_ready(dn_ready), .out_data(dn_data));
   end
endmodule

// File: rtl/stream_reg_slice_chk.sv
module stream_reg_slice_chk
   import slice_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int MODE   = MODE_FWD
) (
   input logic              clk,
   input logic              rst,
   input logic              up_valid,
   input logic              up_ready,
   input logic [DATA_W-1:0] up_data,
   input logic              dn_valid,
   input logic              dn_ready,
   input logic [DATA_W-1:0] dn_data
);
   // R3
   hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      dn_valid && !dn_ready |=> dn_valid && $stable(dn_data));

   if (MODE == MODE_FWD) begin : g_fwd_chk
      // R4
      fwd_ready_chk: assert property (@(posedge clk) disable iff (rst)
         (!dn_valid || dn_ready) |-> up_ready);
      // R4
      fwd_latency_chk: assert property (@(posedge clk) disable iff (rst)
         up_valid && up_ready |=> dn_valid && dn_data == $past(up_data));
   end

   if (MODE == MODE_BWD) begin : g_bwd_chk
      // R5
      bwd_pass_chk: assert property (@(posedge clk) disable iff (rst)
         up_valid && up_ready |-> dn_valid && dn_data == up_data);
      // R5
      bwd_skid_chk: assert property (@(posedge clk) disable iff (rst)
         up_valid && up_ready && !dn_ready |=> !up_ready && dn_valid);
   end

   if (MODE == MODE_HALF) begin : g_half_chk
      // R6
      half_excl_chk: assert property (@(posedge clk) disable iff (rst)
         !(up_ready && dn_valid));
      // R6
      half_rise_chk: assert property (@(posedge clk) disable iff (rst)
         $rose(dn_valid) |-> $past(up_valid && up_ready));
   end
endmodule

bind stream_reg_slice stream_reg_slice_chk #(.DATA_W(DATA_W), .MODE(MODE)) u_chk (
   .clk(clk), .rst(rst),
   .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
   .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data));

// File: tb/stream_reg_slice_test.sv
`timescale 1ns/1ps
module stream_reg_slice_test;
   localparam int W      = 8;
   localparam int NBEATS = 12;
   localparam int NPAT   = 6;
   localparam int LIMIT  = 400;

   // {source offer pattern, sink ready pattern}, bit i used in cycle i mod 16
   localparam logic [31:0] PATS [NPAT] = '{
      32'hFFFF_FFFF, 32'hFFFF_0F0F, 32'hAAAA_FFFF,
      32'hFFFF_3333, 32'h5B6D_C3A5, 32'hFFFF_0001 };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic         up_valid [4];
   logic         up_ready [4];
   logic [W-1:0] up_data  [4];
   logic         dn_valid [4];
   logic         dn_ready [4];
   logic [W-1:0] dn_data  [4];

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   for (genvar m = 0; m < 4; m++) begin : g_mode
      stream_reg_slice #(.DATA_W(W), .MODE(m)) uut (
         .clk(clk), .rst(rst),
         .up_valid(up_valid[m]), .up_ready(up_ready[m]), .up_data(up_data[m]),
         .dn_valid(dn_valid[m]), .dn_ready(dn_ready[m]), .dn_data(dn_data[m]));
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      for (int m = 0; m < 4; m++) begin
         up_valid[m] = 1'b0; up_data[m] = '0; dn_ready[m] = 1'b0;
      end
      @(negedge clk);
      for (int m = 0; m < 4; m++) begin
         // R2: state while reset is held
         check(dn_valid[m] == 1'b0, "R2", int'(dn_valid[m]), 0);
         check(up_ready[m] == 1'b1, "R2", int'(up_ready[m]), 1);
      end
      rst = 1'b0;
      @(negedge clk);
      for (int m = 0; m < 4; m++) begin
         // R2: first cycle after release
         check(dn_valid[m] == 1'b0 && up_ready[m] == 1'b1, "R2",
               int'({dn_valid[m], up_ready[m]}), 1);
      end
   endtask

   // one stream of NBEATS through mode m under pattern p
   task automatic run(input int m, input int p);
      int sent = 0, got = 0, cyc = 0, first_got_cyc = -1;
      bit pending = 0, prev_stall = 0;
      logic [W-1:0] prev_data = '0;
      logic [W-1:0] base = W'(8'h30 + 16 * p + m);
      bit ur_before;
      do_reset();
      while (got < NBEATS && cyc < LIMIT) begin
         // drive for the coming edge (already at a negedge)
         if (!pending && sent < NBEATS && PATS[p][16 + (cyc % 16)]) begin
            pending = 1;
         end
         up_valid[m] = pending;
         up_data[m]  = pending ? W'(base + sent) : W'(8'hEE);
         dn_ready[m] = PATS[p][cyc % 16];
         #1;
         if (prev_stall) begin
            // R3: stalled beat held with the same data
            check(dn_valid[m] && dn_data[m] == prev_data, "R3", int'(dn_data[m]), int'(prev_data));
         end
         if (m == 0 && (!dn_valid[m] || dn_ready[m])) begin
            // R4: forward ready when empty or draining
            check(up_ready[m] == 1'b1, "R4", int'(up_ready[m]), 1);
         end
         if (m == 2) begin
            // R6: never ready and valid together
            check(!(up_ready[m] && dn_valid[m]), "R6", int'({up_ready[m], dn_valid[m]}), 0);
         end
         if (m == 1 && up_valid[m] && up_ready[m]) begin
            // R5: same-cycle pass-through
            check(dn_valid[m] && dn_data[m] == up_data[m], "R5", int'(dn_data[m]), int'(up_data[m]));
         end
         if (m == 1 || m == 3) begin
            // R7: up_ready must not follow dn_ready within a cycle
            ur_before = up_ready[m];
            dn_ready[m] = ~dn_ready[m];
            #1;
            check(up_ready[m] == ur_before, "R7", int'(up_ready[m]), int'(ur_before));
            dn_ready[m] = ~dn_ready[m];
            #1;
         end
         prev_stall = dn_valid[m] && !dn_ready[m];
         prev_data  = dn_data[m];
         if (dn_valid[m] && dn_ready[m]) begin
            // R8: in order, intact
            check(dn_data[m] == W'(base + got), "R8", int'(dn_data[m]), int'(W'(base + got)));
            got++;
         end
         if (up_valid[m] && up_ready[m]) begin
            if (m == 1 && !dn_ready[m]) begin
               @(negedge clk);
               // R5: skid now holds the beat, ready drops
               check(up_ready[m] == 1'b0, "R5", int'(up_ready[m]), 0);
               pending = 0; sent++; cyc++;
               continue;
            end
            pending = 0;
            sent++;
         end
         @(negedge clk);
         cyc++;
      end
      // R8: every beat delivered (R1: each legal mode elaborated and runs)
      check(got == NBEATS, "R8", got, NBEATS);
      if (p == 0) begin
         int exp_cyc = (m == 1) ? NBEATS : (m == 2) ? 2 * NBEATS : NBEATS + 1;
         // R9 / R6: throughput with a free-running sink
         check(cyc == exp_cyc, (m == 2) ? "R6" : "R9", cyc, exp_cyc);
      end
      up_valid[m] = 1'b0;
      dn_ready[m] = 1'b0;
   endtask

   initial begin
      for (int m = 0; m < 4; m++) begin
         up_valid[m] = 1'b0; up_data[m] = '0; dn_ready[m] = 1'b0;
      end
      for (int m = 0; m < 4; m++) begin
         for (int p = 0; p < NPAT; p++) begin
            run(m, p);
         end
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #1_000_000;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule